// File: doc/BRIEF.md
# CAN Controller Operating-Mode Manager

This block holds the operating mode of a CAN controller and decides, cycle by cycle, which of its paths may work. There are seven settled modes: initialization, normal, listen-only, loopback, sleep, disable and stop. One transient state sits between initialization (or sleep) and bus activity. In that state the block waits for the bus to become quiet. Software asks for a mode by holding level request bits. The block reports the mode it has actually reached through a one-hot acknowledge vector. It also gates the configuration write strobe, and it drives the enables for the transmit, receive, bus-drive and internal-loopback paths. The protocol engine that uses these enables is outside this block.

After reset the controller sits in initialization mode, and only there may the configuration registers be written. Changing the configuration while the controller runs takes two steps. The controller must first be parked in sleep mode, and only then moved into initialization. A sleep request waits for the bus to be idle. On the way back to the bus, the block counts bit-time strobes on which the sampled bus level is recessive. The operating mode starts only after eleven such bits in a row.

All pins are plain level control and status signals. No data stream crosses this block, so it has no valid/ready handshake and no back-pressure.

Top module: `can_mode_ctrl`

## Requirements
- R1: While reset is held and right after it, the mode is initialization: `mode_ack` equals 7'b0000001 and every path enable is low. The bit positions of `mode_ack` are init=0, normal=1, listen=2, loopback=3, sleep=4, disable=5, stop=6.
- R2: `cfg_wr_en` follows `cfg_wr_req` only while `mode_ack[0]` is set. In every other mode or state the strobe is dropped.
- R3: From normal, listen-only or loopback, holding `req_init` has no effect. Initialization is reached only from sleep: `req_init` there moves the block to initialization on the next clock.
- R4: In normal mode `tx_en`, `rx_en` and `bus_drive_en` are high and `loop_en` is low. Normal is the only mode in which `bus_drive_en` is high.
- R5: In listen-only mode only `rx_en` is high, so the bus stays recessive and no acknowledge is driven.
- R6: In loopback mode `tx_en`, `rx_en` and `loop_en` are high and `bus_drive_en` is low. If both are requested, `req_loop` wins over `req_listen`. While operating, the block switches among normal, listen-only and loopback on the next clock after those requests change.
- R7: When initialization is left (`req_init` low), or sleep is left (`req_sleep` low), the block enters a sync state. There all acknowledge bits and path enables are low. On the 11th consecutive `bit_tick` with `rx_bit`=1 it moves to the operating mode chosen by R6. A tick with `rx_bit`=0 restarts the count.
- R8: A sleep request from an operating mode takes effect only on a clock where `bus_idle` is high. Until then the previous acknowledge stays set.
- R9: In sleep mode the exits have a fixed priority: `req_init` first, then `req_stop`, then `req_disable`, then `req_sleep` going low (to sync).
- R10: Stop and disable modes set their acknowledge bit with all paths off. Each returns to sleep when its request is released.
- R11: At most one bit of `mode_ack` is set at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_init | input | 1 | Initialization mode request |
| req_sleep | input | 1 | Sleep mode request |
| req_listen | input | 1 | Listen-only request |
| req_loop | input | 1 | Loopback request |
| req_disable | input | 1 | Disable request (honoured in sleep) |
| req_stop | input | 1 | Stop request (honoured in sleep) |
| bus_idle | input | 1 | Bus is between frames |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| rx_bit | input | 1 | Sampled bus level, 1 = recessive |
| cfg_wr_req | input | 1 | Configuration write strobe from the register file |
| cfg_wr_en | output | 1 | Gated configuration write strobe |
| mode_ack | output | 7 | One-hot acknowledge of the settled mode |
| tx_en | output | 1 | Transmit path enable |
| rx_en | output | 1 | Receive path enable |
| bus_drive_en | output | 1 | Permission to drive dominant bits on the bus |
| loop_en | output | 1 | Route transmit stream to the receiver internally |

## Verification
The mode register drives every output, so a wrong internal state shows at the ports on the clock right after the bad transition. The acknowledge vector and the path enables would no longer agree with the mode the requests call for. A faulty sync counter leaves too early or too late: the first operating acknowledge appears on a tick other than the 11th recessive one, and this is visible within that one bit time. A leak in the write gate shows as `cfg_wr_en` pulsing in the same cycle as an ignored write strobe.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  typedef enum logic [2:0] {
    M_INIT    = 3'd0,
    M_NORMAL  = 3'd1,
    M_LISTEN  = 3'd2,
    M_LOOP    = 3'd3,
    M_SLEEP   = 3'd4,
    M_DISABLE = 3'd5,
    M_STOP    = 3'd6,
    M_SYNC    = 3'd7
  } mode_e;

  localparam int unsigned ACK_W = 7;

  function automatic mode_e op_pick(input logic loop_r, input logic listen_r);
    if (loop_r)        return M_LOOP;
    else if (listen_r) return M_LISTEN;
    else               return M_NORMAL;
  endfunction

  function automatic logic is_oper(input mode_e m);
    return (m == M_NORMAL) || (m == M_LISTEN) || (m == M_LOOP);
  endfunction
endpackage

// File: rtl/can_sync_cnt.sv
module can_sync_cnt #(
  parameter int unsigned IDLE_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic bit_tick,
  input  logic rx_bit,
  output logic done
);
  localparam int unsigned CW = $clog2(IDLE_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_BITS - 1);

  logic [CW-1:0] run_q;

  assign done = active && bit_tick && rx_bit && (run_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run_q <= '0;
    else if (!active || done)   run_q <= '0;
    else if (bit_tick)          run_q <= rx_bit ? run_q + 1'b1 : '0;
  end

  // R7
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q < CW'(IDLE_BITS));

  // R7
  dominant_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && bit_tick && !rx_bit) |=> (run_q == '0));
endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
  import can_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_init,
  input  logic  req_sleep,
  input  logic  req_listen,
  input  logic  req_loop,
  input  logic  req_disable,
  input  logic  req_stop,
  input  logic  bus_idle,
  input  logic  sync_done,
  output mode_e mode_q
);
  mode_e nxt;

  always_comb begin
    nxt = mode_q;
    unique case (mode_q)
      M_INIT:    if (!req_init) nxt = M_SYNC;
      M_SYNC:    if (sync_done) nxt = op_pick(req_loop, req_listen);
      M_NORMAL, M_LISTEN, M_LOOP: begin
        if (req_sleep && bus_idle) nxt = M_SLEEP;
        else                       nxt = op_pick(req_loop, req_listen);
      end
      M_SLEEP: begin
        if (req_init)         nxt = M_INIT;
        else if (req_stop)    nxt = M_STOP;
        else if (req_disable) nxt = M_DISABLE;
        else if (!req_sleep)  nxt = M_SYNC;
      end
      M_STOP:    if (!req_stop)    nxt = M_SLEEP;
      M_DISABLE: if (!req_disable) nxt = M_SLEEP;
      default:   nxt = M_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= M_INIT;
    else        mode_q <= nxt;
  end

  // R3
  no_runtime_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_oper(mode_q) |=> (mode_q != M_INIT));

  // R8
  sleep_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_oper(mode_q) && !bus_idle) |=> (mode_q != M_SLEEP));

  // R10
  stop_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_STOP && !req_stop) |=> (mode_q == M_SLEEP));
endmodule

// File: rtl/can_path_dec.sv
module can_path_dec
  import can_mode_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  mode_e            mode_q,
  input  logic             cfg_wr_req,
  output logic [ACK_W-1:0] mode_ack,
  output logic             cfg_wr_en,
  output logic             tx_en,
  output logic             rx_en,
  output logic             bus_drive_en,
  output logic             loop_en
);
  always_comb begin
    mode_ack = '0;
    if (mode_q != M_SYNC) mode_ack[mode_q] = 1'b1;
  end

  assign cfg_wr_en    = cfg_wr_req && (mode_q == M_INIT);
  assign tx_en        = (mode_q == M_NORMAL) || (mode_q == M_LOOP);
  assign rx_en        = is_oper(mode_q);
  assign bus_drive_en = (mode_q == M_NORMAL);
  assign loop_en      = (mode_q == M_LOOP);

  // R11
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mode_ack));

  // R2
  cfg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |-> mode_ack[0]);

  // R6
  loop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> (!bus_drive_en && rx_en));
endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import can_mode_pkg::*;
#(
  parameter int unsigned IDLE_BITS = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_init,
  input  logic             req_sleep,
  input  logic             req_listen,
  input  logic             req_loop,
  input  logic             req_disable,
  input  logic             req_stop,
  input  logic             bus_idle,
  input  logic             bit_tick,
  input  logic             rx_bit,
  input  logic             cfg_wr_req,
  output logic             cfg_wr_en,
  output logic [ACK_W-1:0] mode_ack,
  output logic             tx_en,
  output logic             rx_en,
  output logic             bus_drive_en,
  output logic             loop_en
);
  mode_e mode_q;
  logic  sync_done;

  can_sync_cnt #(.IDLE_BITS(IDLE_BITS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (mode_q == M_SYNC),
    .bit_tick (bit_tick),
    .rx_bit   (rx_bit),
    .done     (sync_done)
  );

  can_mode_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_init    (req_init),
    .req_sleep   (req_sleep),
    .req_listen  (req_listen),
    .req_loop    (req_loop),
    .req_disable (req_disable),
    .req_stop    (req_stop),
    .bus_idle    (bus_idle),
    .sync_done   (sync_done),
    .mode_q      (mode_q)
  );

  can_path_dec u_dec (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_q       (mode_q),
    .cfg_wr_req   (cfg_wr_req),
    .mode_ack     (mode_ack),
    .cfg_wr_en    (cfg_wr_en),
    .tx_en        (tx_en),
    .rx_en        (rx_en),
    .bus_drive_en (bus_drive_en),
    .loop_en      (loop_en)
  );

  // R4
  drive_only_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive_en |-> mode_ack[1]);
endmodule

// File: tb/can_mode_ctrl_tb.sv
module can_mode_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_init = 1'b1, req_sleep = 1'b0, req_listen = 1'b0, req_loop = 1'b0;
  logic req_disable = 1'b0, req_stop = 1'b0, bus_idle = 1'b0;
  logic bit_tick = 1'b0, rx_bit = 1'b1, cfg_wr_req = 1'b0;
  logic cfg_wr_en, tx_en, rx_en, bus_drive_en, loop_en;
  logic [6:0] mode_ack;

  int checks = 0;
  int errors = 0;
  bit done_run = 1'b0;

  typedef struct { logic [11:0] val; string tag; } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  can_mode_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_init(req_init), .req_sleep(req_sleep),
    .req_listen(req_listen), .req_loop(req_loop), .req_disable(req_disable),
    .req_stop(req_stop), .bus_idle(bus_idle), .bit_tick(bit_tick),
    .rx_bit(rx_bit), .cfg_wr_req(cfg_wr_req), .cfg_wr_en(cfg_wr_en),
    .mode_ack(mode_ack), .tx_en(tx_en), .rx_en(rx_en),
    .bus_drive_en(bus_drive_en), .loop_en(loop_en)
  );

  // Mode index m: 0 init,1 normal,2 listen,3 loop,4 sleep,5 disable,6 stop,7 sync
  function automatic logic [11:0] expv(int m, logic cfg);
    logic [6:0] a;
    logic tx, rx, dr, lp;
    a  = (m < 7) ? (7'b1 << m) : 7'b0;
    tx = (m == 1) || (m == 3);
    rx = (m == 1) || (m == 2) || (m == 3);
    dr = (m == 1);
    lp = (m == 3);
    return {a, tx, rx, dr, lp, cfg && (m == 0)};
  endfunction

  function automatic logic [11:0] actual();
    return {mode_ack, tx_en, rx_en, bus_drive_en, loop_en, cfg_wr_en};
  endfunction

  // Driver: hold the current inputs through one rising edge, expect mode m after it
  task automatic step(int m, string tag);
    exp_t e;
    e.val = expv(m, cfg_wr_req);
    e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic ticks(int n, logic rx, int m, string tag);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1; rx_bit = rx;
      step(m, tag);
    end
    bit_tick = 1'b0; rx_bit = 1'b1;
  endtask

  // Monitor
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (actual() !== e.val) begin
        errors++;
        $display("FAIL %s: got %b expected %b", e.tag, actual(), e.val);
      end
    end
  end

  initial begin
    #100000;
    if (!done_run) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cfg_wr_req = 1'b1;
    #12;
    // R1 reset value while reset held
    checks++;
    if (actual() !== expv(0, 1'b1)) begin
      errors++;
      $display("FAIL R1: got %b expected %b", actual(), expv(0, 1'b1));
    end
    @(negedge clk); rst_n = 1'b1;
    step(0, "R1");                     // R1 after reset, R2 write passes in init
    cfg_wr_req = 1'b0; step(0, "R2");
    // leave init: sync with writes dropped
    req_init = 1'b0; cfg_wr_req = 1'b1; step(7, "R2");
    cfg_wr_req = 1'b0;
    step(7, "R7");                     // no tick: stay in sync
    ticks(5, 1'b1, 7, "R7");
    ticks(1, 1'b0, 7, "R7");           // dominant restarts count
    ticks(10, 1'b1, 7, "R7");
    ticks(1, 1'b1, 1, "R7");           // 11th recessive bit -> normal
    cfg_wr_req = 1'b1; step(1, "R2");  // write in normal dropped
    cfg_wr_req = 1'b0; step(1, "R4");
    req_listen = 1'b1; step(2, "R5");
    req_loop = 1'b1;   step(3, "R6");  // loop beats listen
    req_listen = 1'b0; step(3, "R6");
    req_loop = 1'b0;   step(1, "R6");
    req_init = 1'b1;   step(1, "R3");  // ignored while operating
    step(1, "R3");
    req_init = 1'b0;
    req_sleep = 1'b1; bus_idle = 1'b0; step(1, "R8");
    step(1, "R8");
    bus_idle = 1'b1; step(4, "R8");
    req_stop = 1'b1; req_disable = 1'b1; step(6, "R9");  // stop beats disable
    step(6, "R10");
    req_stop = 1'b0; step(4, "R10");
    step(5, "R9");
    req_disable = 1'b0; step(4, "R10");
    req_sleep = 1'b0; step(7, "R9");   // wake to sync
    req_listen = 1'b1;
    ticks(10, 1'b1, 7, "R7");
    ticks(1, 1'b1, 2, "R7");           // resume in listen
    req_listen = 1'b0; req_sleep = 1'b1; step(4, "R8");
    req_init = 1'b1; req_stop = 1'b1; step(0, "R9");  // init beats stop
    req_stop = 1'b0; cfg_wr_req = 1'b1; step(0, "R3");
    cfg_wr_req = 1'b0;
    repeat (3) @(negedge clk);
    done_run = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule